// File: doc/BRIEF.md
# Interrupt Request and Masking Unit

This block gathers seven status sources into one interrupt pin. The sources are USB connection, USB suspend, VBUS, two supply rails, a busy flag and card presence. Each raw level passes through a two-flop synchronizer. A change in either direction then sets a sticky bit in the request register, even when the source is disabled. The synchronized levels are also shown live in a status register.

Only enabled sources drive the interrupt. The pin has two modes. In the held mode it stays asserted until the status register is read. In the timed mode it is a pulse that lasts a fixed number of millisecond ticks. The active polarity is programmable. While the logic is asleep the pin's output enable is dropped, so a board pull resistor sets the pin level.

The card source records changes only while card-reader mode is active. The host bus and the analog detectors sit outside the block. They reach it through write enables, read strobes and level inputs.

Top module: `intReqUnit`

## Requirements
- R1: After reset the request register is zero, every source is disabled, the held mode and active-low polarity are selected, and with `awake` high `intOut` is 1 and `intOe` is 1.
- R2: Source bit positions are: 0 USB connection, 1 USB suspend, 2 VBUS, 3 rail A, 4 rail B, 5 busy, 6 card. A rising or falling change on a source sets its request bit on the third clock edge after the raw input changes. This happens whether or not the source is enabled.
- R3: A cycle with `reqRd` high clears all request bits at the next edge. A bit whose change is detected in that same cycle stays set.
- R4: `statusBits` follows `srcRaw` two edges later, and reads have no effect on it.
- R5: A change on a source sets the interrupt only if its `enWrData` bit was written as 1 (1 = enabled). Disabled changes leave `intOut` inactive.
- R6: In held mode (`cfgLatch`=1) the interrupt stays active until a cycle with `statusRd` high. If an enabled change is detected in that same cycle, the interrupt stays active.
- R7: In timed mode (`cfgLatch`=0) an enabled change makes the interrupt active for PULSE_TICKS `msTick` pulses. A further enabled change during the pulse restarts the count.
- R8: With `cfgActHigh`=1 the active level of `intOut` is 1 and the inactive level is 0. With `cfgActHigh`=0 the levels are reversed.
- R9: With `awake` low `intOe` is 0. Change detection and the request register keep working.
- R10: A change on the card source (bit 6) sets its request bit only while `cardMode` is 1. `statusBits[6]` still follows the input when `cardMode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcRaw | input | 7 | Raw source levels |
| enWrEn | input | 1 | Write strobe for the enable register |
| enWrData | input | 7 | Enable bits, 1 = source may interrupt |
| cfgWrEn | input | 1 | Write strobe for the pin configuration; clears any active interrupt |
| cfgLatch | input | 1 | 1 = held until status read, 0 = timed pulse |
| cfgActHigh | input | 1 | 1 = active-high pin |
| statusRd | input | 1 | Status register read strobe |
| reqRd | input | 1 | Request register read strobe |
| cardMode | input | 1 | 1 = card-reader mode, 0 = pass-through |
| awake | input | 1 | Logic awake flag |
| msTick | input | 1 | One-cycle pulse each millisecond |
| reqBits | output | 7 | Request register |
| statusBits | output | 7 | Synchronized live source levels |
| intOut | output | 1 | Interrupt pin level |
| intOe | output | 1 | Interrupt pin output enable |

## Verification
A raw input change shows in `statusBits` two edges later. It reaches `reqBits` and `intOut` on the third edge. Strobes such as `reqRd`, `statusRd` and the enable and config writes act on the next edge, while `intOe` follows `awake` at once. The bench keeps a behavioural reference that records raw samples in a queue and applies these delays. It drives inputs on the falling edge and compares every output a quarter period after each rising edge. The targeted checks place each strobe in exactly the cycle where a detected change is live, so the same-cycle cases of R3 and R6 are hit.

// File: rtl/irqPkg.sv
package irqPkg;
  // Strobes issued by the control toward the datapath each cycle
  typedef struct packed {
    logic reqClr;
    logic pendSet;
    logic pendClr;
    logic tmrLoad;
    logic tmrDec;
    logic tmrClr;
  } irqStrobe_t;
endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[0] <= '0;
          else       stg[0] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[s] <= '0;
          else       stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stg[STAGES-1];
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int NUM_SRC     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int CARD_IDX    = 6,
  parameter int PULSE_TICKS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  logic               enWrEn,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               cardMode,
  input  irqStrobe_t         strb,
  output logic [NUM_SRC-1:0] reqBits,
  output logic [NUM_SRC-1:0] statusBits,
  output logic               hitAny,
  output logic               pendQ,
  output logic               tmrBusy
);
  localparam int TMR_W = $clog2(PULSE_TICKS + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(PULSE_TICKS);

  logic [NUM_SRC-1:0] syncLvl;
  logic [NUM_SRC-1:0] prevLvl;
  logic [NUM_SRC-1:0] evtVec;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] reqQ;
  logic [TMR_W-1:0]   tmrQ;
  logic               pendR;

  syncChain #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (srcRaw),
    .dOut (syncLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  // Both edges count; the card source is gated by the reader mode
  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_evt
      if (i == CARD_IDX) begin : g_card
        assign evtVec[i] = (syncLvl[i] ^ prevLvl[i]) & cardMode;
      end else begin : g_plain
        assign evtVec[i] = syncLvl[i] ^ prevLvl[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       enableQ <= '0;
    else if (enWrEn) enableQ <= enWrData;
  end

  // A change in the read cycle survives the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= (strb.reqClr ? '0 : reqQ) | evtVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendR <= 1'b0;
    else if (strb.pendClr) pendR <= 1'b0;
    else if (strb.pendSet) pendR <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            tmrQ <= '0;
    else if (strb.tmrClr)                 tmrQ <= '0;
    else if (strb.tmrLoad)                tmrQ <= TMR_LOAD;
    else if (strb.tmrDec && tmrQ != '0)   tmrQ <= tmrQ - 1'b1;
  end

  assign hitAny     = |(evtVec & enableQ);
  assign reqBits    = reqQ;
  assign statusBits = syncLvl;
  assign pendQ      = pendR;
  assign tmrBusy    = (tmrQ != '0);
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgLatch,
  input  logic       cfgActHigh,
  input  logic       statusRd,
  input  logic       reqRd,
  input  logic       msTick,
  input  logic       awake,
  input  logic       hitAny,
  input  logic       pendQ,
  input  logic       tmrBusy,
  output irqStrobe_t strb,
  output logic       latchModeQ,
  output logic       actHighQ,
  output logic       intOut,
  output logic       intOe
);
  logic intActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchModeQ <= 1'b1;
      actHighQ   <= 1'b0;
    end else if (cfgWrEn) begin
      latchModeQ <= cfgLatch;
      actHighQ   <= cfgActHigh;
    end
  end

  always_comb begin
    strb        = '0;
    strb.reqClr = reqRd;
    if (cfgWrEn) begin
      strb.pendClr = 1'b1;
      strb.tmrClr  = 1'b1;
    end else if (latchModeQ) begin
      strb.pendSet = hitAny;
      strb.pendClr = statusRd & ~hitAny;
    end else begin
      strb.tmrLoad = hitAny;
      strb.tmrDec  = msTick & tmrBusy & ~hitAny;
    end
  end

  assign intActive = latchModeQ ? pendQ : tmrBusy;
  assign intOut    = intActive ? actHighQ : ~actHighQ;
  assign intOe     = awake;
endmodule

// File: rtl/intReqUnit.sv
module intReqUnit
  import irqPkg::*;
#(
  parameter int NUM_SRC     = 7,
  parameter int SYNC_STAGES = 2,
  parameter int CARD_IDX    = 6,
  parameter int PULSE_TICKS = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcRaw,
  input  logic               enWrEn,
  input  logic [NUM_SRC-1:0] enWrData,
  input  logic               cfgWrEn,
  input  logic               cfgLatch,
  input  logic               cfgActHigh,
  input  logic               statusRd,
  input  logic               reqRd,
  input  logic               cardMode,
  input  logic               awake,
  input  logic               msTick,
  output logic [NUM_SRC-1:0] reqBits,
  output logic [NUM_SRC-1:0] statusBits,
  output logic               intOut,
  output logic               intOe
);
  irqStrobe_t strb;
  logic hitAny;
  logic pendQ;
  logic tmrBusy;
  logic latchModeQ;
  logic actHighQ;

  irqDatapath #(
    .NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES),
    .CARD_IDX(CARD_IDX), .PULSE_TICKS(PULSE_TICKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .srcRaw(srcRaw), .enWrEn(enWrEn),
    .enWrData(enWrData), .cardMode(cardMode), .strb(strb),
    .reqBits(reqBits), .statusBits(statusBits), .hitAny(hitAny),
    .pendQ(pendQ), .tmrBusy(tmrBusy)
  );

  irqControl ctl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgLatch(cfgLatch),
    .cfgActHigh(cfgActHigh), .statusRd(statusRd), .reqRd(reqRd),
    .msTick(msTick), .awake(awake), .hitAny(hitAny), .pendQ(pendQ),
    .tmrBusy(tmrBusy), .strb(strb), .latchModeQ(latchModeQ),
    .actHighQ(actHighQ), .intOut(intOut), .intOe(intOe)
  );
endmodule

// File: rtl/intReqUnitChk.sv
module intReqUnitChk #(
  parameter int NUM_SRC  = 7,
  parameter int CARD_IDX = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqBits,
  input logic [NUM_SRC-1:0] statusBits,
  input logic               reqRd,
  input logic               statusRd,
  input logic               cfgWrEn,
  input logic               cardMode,
  input logic               intOut,
  input logic               hitAny,
  input logic               latchModeQ,
  input logic               actHighQ
);
  logic isActive;
  assign isActive = (intOut == actHighQ);

  p_new_req_needs_change_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((reqBits & ~$past(reqBits)) != '0) |-> ($past(statusBits) != $past(statusBits, 2)));

  p_req_read_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqRd |=> ((reqBits & $past(reqBits) & ~($past(statusBits) ^ $past(statusBits, 2))) == '0));

  p_rise_needs_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(isActive) && !$past(cfgWrEn)) |-> $past(hitAny));

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latchModeQ && isActive && !statusRd && !cfgWrEn) |=> isActive);

  p_card_passthru_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqBits[CARD_IDX]) |-> $past(cardMode));
endmodule

bind intReqUnit intReqUnitChk #(.NUM_SRC(NUM_SRC), .CARD_IDX(CARD_IDX)) chk_i (
  .clk(clk), .rstN(rstN), .reqBits(reqBits), .statusBits(statusBits),
  .reqRd(reqRd), .statusRd(statusRd), .cfgWrEn(cfgWrEn), .cardMode(cardMode),
  .intOut(intOut), .hitAny(hitAny), .latchModeQ(latchModeQ), .actHighQ(actHighQ)
);

// File: tb/intReqUnit_tb_top.sv
module intReqUnit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 7;
  localparam int PULSE      = 10;
  localparam int TICK_GAP   = 8;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] srcRaw = '0;
  logic enWrEn = 0, cfgWrEn = 0, cfgLatch = 1, cfgActHigh = 0;
  logic [NSRC-1:0] enWrData = '0;
  logic statusRd = 0, reqRd = 0, cardMode = 1, awake = 1, msTick = 0;
  logic [NSRC-1:0] reqBits, statusBits;
  logic intOut, intOe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit tickEn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intReqUnit #(.PULSE_TICKS(PULSE)) dut_i (
    .clk(clk), .rstN(rstN), .srcRaw(srcRaw), .enWrEn(enWrEn), .enWrData(enWrData),
    .cfgWrEn(cfgWrEn), .cfgLatch(cfgLatch), .cfgActHigh(cfgActHigh),
    .statusRd(statusRd), .reqRd(reqRd), .cardMode(cardMode), .awake(awake),
    .msTick(msTick), .reqBits(reqBits), .statusBits(statusBits),
    .intOut(intOut), .intOe(intOe)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [NSRC-1:0] hist[$];
  logic [NSRC-1:0] mReq, mEn;
  bit mPend, mLatch, mAH;
  int mTmr;

  always @(posedge clk) begin
    logic [NSRC-1:0] evt;
    bit hit;
    if (!rstN) begin
      hist = {7'd0, 7'd0, 7'd0};
      mReq = '0; mEn = '0; mPend = 0; mTmr = 0; mLatch = 1; mAH = 0;
    end else begin
      evt = hist[$-1] ^ hist[$-2];
      if (!cardMode) evt[6] = 1'b0;
      hit = |(evt & mEn);
      mReq = (reqRd ? '0 : mReq) | evt;
      if (cfgWrEn) begin
        mPend = 0; mTmr = 0;
      end else if (mLatch) begin
        mPend = hit || (mPend && !statusRd);
      end else if (hit) begin
        mTmr = PULSE;
      end else if (msTick && mTmr > 0) begin
        mTmr--;
      end
      if (enWrEn) mEn = enWrData;
      if (cfgWrEn) begin mLatch = cfgLatch; mAH = cfgActHigh; end
      hist.push_back(srcRaw);
      void'(hist.pop_front());
      #(CLK_PERIOD/4);
      begin
        bit act;
        act = mLatch ? mPend : (mTmr != 0);
        check("R2/R3 reqBits", reqBits, mReq);
        check("R4 statusBits", statusBits, hist[$-1]);
        check("R8 intOut", intOut, act ? mAH : !mAH);
        check("R9 intOe", intOe, awake);
      end
    end
  end

  // millisecond tick source
  always @(negedge clk) begin
    if (tickEn && (cyc % TICK_GAP == 0)) msTick <= 1'b1;
    else msTick <= 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flip(int b);
    srcRaw[b] = ~srcRaw[b];
  endtask

  initial begin
    step(3);
    rstN = 1;
    step(1);
    // R1 reset state
    check("R1 reqBits", reqBits, 0);
    check("R1 intOut", intOut, 1);
    check("R1 intOe", intOe, 1);

    // R2/R4/R5: disabled source change still recorded, no interrupt
    flip(0); flip(3);
    step(1);
    check("R4 status lag", statusBits[3], 0);
    step(1);
    check("R4 status", statusBits[3], 1);
    step(1);
    check("R2 req bit0", reqBits[0], 1);
    check("R2 req bit3", reqBits[3], 1);
    check("R5 disabled no int", intOut, 1);
    flip(3); step(3);
    check("R2 falling edge", reqBits[3], 1);

    // R3 clear, and same-cycle keep
    reqRd = 1; step(1); reqRd = 0;
    check("R3 cleared", reqBits, 0);
    flip(1); step(2);
    reqRd = 1; step(1); reqRd = 0;
    check("R3 same-cycle kept", reqBits, 7'b0000010);
    statusRd = 1; step(1); statusRd = 0;
    check("R4 read no effect", statusBits[1], 1);
    reqRd = 1; step(1); reqRd = 0;
    check("R3 second read", reqBits, 0);

    // R5/R6 held mode, active-low
    enWrData = 7'b1000100; enWrEn = 1; step(1); enWrEn = 0;
    flip(2); step(3);
    check("R5 enabled int", intOut, 0);
    step(5);
    check("R6 held", intOut, 0);
    statusRd = 1; step(1); statusRd = 0;
    check("R6 status read clears", intOut, 1);
    flip(2); step(2);
    statusRd = 1; step(1); statusRd = 0;
    check("R6 same-cycle event kept", intOut, 0);
    statusRd = 1; step(1); statusRd = 0;
    check("R6 cleared again", intOut, 1);

    // R8 active-high polarity
    cfgLatch = 1; cfgActHigh = 1; cfgWrEn = 1; step(1); cfgWrEn = 0;
    check("R8 inactive high-pol", intOut, 0);
    flip(2); step(3);
    check("R8 active high-pol", intOut, 1);
    statusRd = 1; step(1); statusRd = 0;
    check("R8 cleared", intOut, 0);

    // R7 timed pulse with restart
    cfgLatch = 0; cfgActHigh = 1; cfgWrEn = 1; step(1); cfgWrEn = 0;
    tickEn = 1;
    flip(2); step(3);
    check("R7 pulse start", intOut, 1);
    step(PULSE * TICK_GAP + TICK_GAP);
    check("R7 pulse ended", intOut, 0);
    flip(2); step(3);
    check("R7 second pulse", intOut, 1);
    step(6 * TICK_GAP);
    flip(2); step(3);
    step(6 * TICK_GAP);
    check("R7 restarted", intOut, 1);
    step(6 * TICK_GAP);
    check("R7 restart ended", intOut, 0);

    // R9 sleep
    reqRd = 1; step(1); reqRd = 0;
    awake = 0; #1;
    check("R9 oe off", intOe, 0);
    flip(0); step(3);
    check("R9 detect asleep", reqBits[0], 1);
    awake = 1; #1;
    check("R9 oe on", intOe, 1);

    // R10 card source gating
    step(1);
    reqRd = 1; step(1); reqRd = 0;
    cardMode = 0;
    flip(6); step(3);
    check("R10 passthru no req", reqBits[6], 0);
    check("R10 status follows", statusBits[6], 1);
    check("R10 no int", intOut, 0);
    cardMode = 1;
    flip(6); step(3);
    check("R10 reader req", reqBits[6], 1);
    check("R10 reader int", intOut, 1);
    tickEn = 0;
    step(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule